// File: doc/BRIEF.md
# Write-Once Node Unique Identifier Registers

This block stores a 64-bit node unique identifier as two 32-bit halves, an upper word and a lower word. After a hardware reset both halves are zero and unlocked. Each half accepts exactly one load, then locks and ignores every later write until the next hardware reset.

A load can come from one of two sources. The first is a serial non-volatile memory loader, reduced here to a word strobe with a half select. The second is a single configuration-space write at either of two alias addresses per half. An input that reports whether the memory is fitted decides which source may load. When the memory is fitted, configuration writes have no effect. When it is absent, loader words have no effect.

Both halves can be read through a configuration-space read port and a memory-mapped read port. A validity output tells the link-enable logic when both halves are locked and the identifier is non-zero. An all-zero identifier is never valid.

Top module: `uid_lock_regs`

## Requirements
- R1: A synchronous hardware reset clears both halves to zero, clears both lock flags and drives `uid_valid` low.
- R2: When `rom_present` is 1, a `rom_wr_valid` strobe loads `rom_wr_data` into the half picked by `rom_wr_sel` (1 = upper, 0 = lower) and locks that half. The new value is visible one clock later.
- R3: When `rom_present` is 0, a configuration write loads the upper half at address 0x70 or its alias 0x80, and the lower half at 0x74 or its alias 0x84. The write locks that half.
- R4: A locked half keeps its value. Later loader strobes and configuration writes to it, from either source and at either alias, change nothing.
- R5: When `rom_present` is 1, configuration writes to the load addresses have no effect. When it is 0, loader strobes have no effect.
- R6: Each half has its own lock flag. Loading one half leaves the other half unlocked and still loadable.
- R7: A configuration read returns the upper half at 0x70 and 0x80, the lower half at 0x74 and 0x84, and zero at every other address.
- R8: A memory-mapped read returns the upper half at 0x24, the lower half at 0x28, and zero at every other address.
- R9: `uid_valid` is 1 exactly when both halves are locked and the 64-bit value is non-zero.
- R10: `uid_vendor` is bits 31:8 of the upper half. `uid_chip` is the upper half's bits 7:0 followed by the 32 bits of the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| rom_present | input | 1 | Non-volatile ID memory is fitted |
| rom_wr_valid | input | 1 | Loader word strobe |
| rom_wr_sel | input | 1 | Loader half select, 1 = upper |
| rom_wr_data | input | 32 | Loader word |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Configuration write address |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_addr | input | 8 | Configuration read address |
| cfg_rd_data | output | 32 | Configuration read data, combinational |
| mmio_rd_addr | input | 8 | Memory-mapped read address |
| mmio_rd_data | output | 32 | Memory-mapped read data, combinational |
| hi_locked | output | 1 | Upper half has been loaded |
| lo_locked | output | 1 | Lower half has been loaded |
| uid_vendor | output | 24 | Vendor field of the identifier |
| uid_chip | output | 40 | Chip field of the identifier |
| uid_valid | output | 1 | Identifier locked and non-zero |

## Verification
The bench sweeps both source modes against all four alias pairings. It tries second loads through every alias and through the loader. A lock that was not one-shot would let the second value overwrite the first. A lock shared between halves would block the second half from loading. An alias that is missed would leave a half at zero.

Full sweeps over all 256 addresses on both read ports catch a decoder that answers at the wrong address. A half that is locked with zero data checks that `uid_valid` depends on the value as well as on the locks.

// File: rtl/uid_pkg.sv
package uid_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_ROM  = 2'd1,
        SRC_CFG  = 2'd2
    } load_src_e;

    typedef struct packed {
        logic hit_hi;
        logic hit_lo;
    } half_hit_t;

    function automatic logic addr_match2(input logic [7:0] a,
                                         input logic [7:0] p0,
                                         input logic [7:0] p1);
        return (a == p0) || (a == p1);
    endfunction

endpackage

// File: rtl/uid_cfg_decode.sv
module uid_cfg_decode
    import uid_pkg::*;
#(
    parameter int            ADDR_W   = 8,
    parameter logic [7:0]    HI_ADDR0 = 8'h70,
    parameter logic [7:0]    HI_ADDR1 = 8'h80,
    parameter logic [7:0]    LO_ADDR0 = 8'h74,
    parameter logic [7:0]    LO_ADDR1 = 8'h84
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output half_hit_t         hit
);
    logic [7:0] a8;

    always_comb begin
        a8 = 8'(addr);
        hit.hit_hi = en && addr_match2(a8, HI_ADDR0, HI_ADDR1);
        hit.hit_lo = en && addr_match2(a8, LO_ADDR0, LO_ADDR1);
    end

    always_comb begin
        assert (!(hit.hit_hi && hit.hit_lo)) else $error("assert_decode_exclusive_R3");
    end
endmodule

// File: rtl/uid_half.sv
module uid_half
    import uid_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rom_present,
    input  logic              rom_take,
    input  logic [WORD_W-1:0] rom_data,
    input  logic              cfg_take,
    input  logic [WORD_W-1:0] cfg_data,
    output logic [WORD_W-1:0] value,
    output logic              locked
);
    load_src_e src;

    always_comb begin
        src = SRC_NONE;
        if (!locked) begin
            if (rom_present && rom_take)
                src = SRC_ROM;
            else if (!rom_present && cfg_take)
                src = SRC_CFG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value  <= '0;
            locked <= 1'b0;
        end else begin
            case (src)
                SRC_ROM: begin
                    value  <= rom_data;
                    locked <= 1'b1;
                end
                SRC_CFG: begin
                    value  <= cfg_data;
                    locked <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);
    assert_locked_value_stable_R4: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(value));
    assert_no_cfg_when_rom_R5: assert property (@(posedge clk) disable iff (rst)
        (!locked && rom_present && !rom_take) |=> !locked);
    assert_no_rom_when_absent_R5: assert property (@(posedge clk) disable iff (rst)
        (!locked && !rom_present && !cfg_take) |=> !locked);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!locked && value == '0));
endmodule

// File: rtl/uid_rd_mux.sv
module uid_rd_mux
    import uid_pkg::*;
#(
    parameter int         ADDR_W  = 8,
    parameter int         WORD_W  = 32,
    parameter logic [7:0] MM_HI   = 8'h24,
    parameter logic [7:0] MM_LO   = 8'h28
) (
    input  half_hit_t         cfg_hit,
    input  logic [ADDR_W-1:0] mmio_addr,
    input  logic [WORD_W-1:0] hi_value,
    input  logic [WORD_W-1:0] lo_value,
    output logic [WORD_W-1:0] cfg_data,
    output logic [WORD_W-1:0] mmio_data
);
    always_comb begin
        unique case (1'b1)
            cfg_hit.hit_hi: cfg_data = hi_value;
            cfg_hit.hit_lo: cfg_data = lo_value;
            default:        cfg_data = '0;
        endcase
    end

    always_comb begin
        if (8'(mmio_addr) == MM_HI)
            mmio_data = hi_value;
        else if (8'(mmio_addr) == MM_LO)
            mmio_data = lo_value;
        else
            mmio_data = '0;
    end
endmodule

// File: rtl/uid_lock_regs.sv
module uid_lock_regs
    import uid_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         WORD_W   = 32,
    parameter int         VEND_W   = 24,
    parameter logic [7:0] CFG_HI0  = 8'h70,
    parameter logic [7:0] CFG_HI1  = 8'h80,
    parameter logic [7:0] CFG_LO0  = 8'h74,
    parameter logic [7:0] CFG_LO1  = 8'h84,
    parameter logic [7:0] MMIO_HI  = 8'h24,
    parameter logic [7:0] MMIO_LO  = 8'h28,
    localparam int        UID_W    = 2 * WORD_W,
    localparam int        CHIP_W   = UID_W - VEND_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rom_present,
    input  logic              rom_wr_valid,
    input  logic              rom_wr_sel,
    input  logic [WORD_W-1:0] rom_wr_data,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wr_addr,
    input  logic [WORD_W-1:0] cfg_wr_data,
    input  logic [ADDR_W-1:0] cfg_rd_addr,
    output logic [WORD_W-1:0] cfg_rd_data,
    input  logic [ADDR_W-1:0] mmio_rd_addr,
    output logic [WORD_W-1:0] mmio_rd_data,
    output logic              hi_locked,
    output logic              lo_locked,
    output logic [VEND_W-1:0] uid_vendor,
    output logic [CHIP_W-1:0] uid_chip,
    output logic              uid_valid
);
    half_hit_t         wr_hit, rd_hit;
    logic [WORD_W-1:0] half_val [2];
    logic [1:0]        half_lock;
    logic [1:0]        rom_take, cfg_take;
    logic [UID_W-1:0]  uid_full;

    uid_cfg_decode #(.ADDR_W(ADDR_W), .HI_ADDR0(CFG_HI0), .HI_ADDR1(CFG_HI1),
                     .LO_ADDR0(CFG_LO0), .LO_ADDR1(CFG_LO1))
    u_wr_dec (.en(cfg_wr_en), .addr(cfg_wr_addr), .hit(wr_hit));

    uid_cfg_decode #(.ADDR_W(ADDR_W), .HI_ADDR0(CFG_HI0), .HI_ADDR1(CFG_HI1),
                     .LO_ADDR0(CFG_LO0), .LO_ADDR1(CFG_LO1))
    u_rd_dec (.en(1'b1), .addr(cfg_rd_addr), .hit(rd_hit));

    assign rom_take[0] = rom_wr_valid && !rom_wr_sel;
    assign rom_take[1] = rom_wr_valid &&  rom_wr_sel;
    assign cfg_take[0] = wr_hit.hit_lo;
    assign cfg_take[1] = wr_hit.hit_hi;

    // index 0 = lower half, index 1 = upper half
    for (genvar g = 0; g < 2; g++) begin : g_half
        uid_half #(.WORD_W(WORD_W)) u_half (
            .clk         (clk),
            .rst         (rst),
            .rom_present (rom_present),
            .rom_take    (rom_take[g]),
            .rom_data    (rom_wr_data),
            .cfg_take    (cfg_take[g]),
            .cfg_data    (cfg_wr_data),
            .value       (half_val[g]),
            .locked      (half_lock[g])
        );
    end

    uid_rd_mux #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .MM_HI(MMIO_HI), .MM_LO(MMIO_LO))
    u_rd_mux (
        .cfg_hit   (rd_hit),
        .mmio_addr (mmio_rd_addr),
        .hi_value  (half_val[1]),
        .lo_value  (half_val[0]),
        .cfg_data  (cfg_rd_data),
        .mmio_data (mmio_rd_data)
    );

    assign uid_full   = {half_val[1], half_val[0]};
    assign hi_locked  = half_lock[1];
    assign lo_locked  = half_lock[0];
    assign uid_vendor = uid_full[UID_W-1 -: VEND_W];
    assign uid_chip   = uid_full[CHIP_W-1:0];
    assign uid_valid  = (&half_lock) && (uid_full != '0);

    assert_valid_after_reset_R1: assert property (@(posedge clk)
        rst |=> !uid_valid);
    assert_valid_needs_locks_R9: assert property (@(posedge clk) disable iff (rst)
        uid_valid |-> (hi_locked && lo_locked));
    assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        uid_valid |=> uid_valid);
endmodule

// File: tb/uid_lock_regs_tb.sv
module uid_lock_regs_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        rom_present, rom_wr_valid, rom_wr_sel;
    logic [31:0] rom_wr_data;
    logic        cfg_wr_en;
    logic [7:0]  cfg_wr_addr, cfg_rd_addr, mmio_rd_addr;
    logic [31:0] cfg_wr_data, cfg_rd_data, mmio_rd_data;
    logic        hi_locked, lo_locked, uid_valid;
    logic [23:0] uid_vendor;
    logic [39:0] uid_chip;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    uid_lock_regs u_dut (
        .clk(clk), .rst(rst), .rom_present(rom_present),
        .rom_wr_valid(rom_wr_valid), .rom_wr_sel(rom_wr_sel), .rom_wr_data(rom_wr_data),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .mmio_rd_addr(mmio_rd_addr), .mmio_rd_data(mmio_rd_data),
        .hi_locked(hi_locked), .lo_locked(lo_locked),
        .uid_vendor(uid_vendor), .uid_chip(uid_chip), .uid_valid(uid_valid)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rom_wr_valid = 0; cfg_wr_en = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    task automatic rom_wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        rom_wr_valid = 1; rom_wr_sel = sel; rom_wr_data = d;
        @(negedge clk);
        rom_wr_valid = 0;
    endtask

    function automatic logic [31:0] cfg_exp(input logic [7:0] a, input logic [31:0] h,
                                            input logic [31:0] l);
        if (a == 8'h70 || a == 8'h80) return h;
        if (a == 8'h74 || a == 8'h84) return l;
        return 32'h0;
    endfunction

    function automatic logic [31:0] mm_exp(input logic [7:0] a, input logic [31:0] h,
                                           input logic [31:0] l);
        if (a == 8'h24) return h;
        if (a == 8'h28) return l;
        return 32'h0;
    endfunction

    task automatic check_state(input string tag, input logic [31:0] h, input logic [31:0] l,
                               input logic hl, input logic ll);
        logic v;
        v = hl && ll && ({h, l} != 64'h0);
        cfg_rd_addr = 8'h70; mmio_rd_addr = 8'h24; #1;
        chk({tag, " R7 cfg hi"}, cfg_rd_data, h);
        chk({tag, " R8 mmio hi"}, mmio_rd_data, h);
        cfg_rd_addr = 8'h84; mmio_rd_addr = 8'h28; #1;
        chk({tag, " R7 cfg lo"}, cfg_rd_data, l);
        chk({tag, " R8 mmio lo"}, mmio_rd_data, l);
        chk({tag, " R6 hi_locked"}, hi_locked, hl);
        chk({tag, " R6 lo_locked"}, lo_locked, ll);
        chk({tag, " R9 valid"}, uid_valid, v);
        chk({tag, " R10 vendor"}, uid_vendor, h[31:8]);
        chk({tag, " R10 chip"}, uid_chip, {h[7:0], l});
    endtask

    initial begin
        rst = 1; rom_present = 0; rom_wr_valid = 0; rom_wr_sel = 0; rom_wr_data = 0;
        cfg_wr_en = 0; cfg_wr_addr = 0; cfg_wr_data = 0; cfg_rd_addr = 0; mmio_rd_addr = 0;
        @(negedge clk);

        for (int p = 0; p < 2; p++) begin
            for (int ha = 0; ha < 2; ha++) begin
                for (int la = 0; la < 2; la++) begin
                    logic [31:0] hv, lv;
                    logic [7:0]  hadr, ladr, hadr2, ladr2;
                    int          k;
                    k     = p * 4 + ha * 2 + la;
                    hv    = 32'h13570000 + k * 32'h01010101 + 32'h9;
                    lv    = 32'hA0B0C0D0 ^ (k * 32'h00110011);
                    hadr  = ha ? 8'h80 : 8'h70;
                    ladr  = la ? 8'h84 : 8'h74;
                    hadr2 = ha ? 8'h70 : 8'h80;
                    ladr2 = la ? 8'h74 : 8'h84;
                    rom_present = p[0];
                    do_reset();
                    check_state("R1 reset", 32'h0, 32'h0, 0, 0);
                    if (p == 0) begin
                        rom_wr(1'b1, ~hv);
                        check_state("R5 rom ignored", 32'h0, 32'h0, 0, 0);
                        cfg_wr(hadr, hv);
                        check_state("R3 hi load", hv, 32'h0, 1, 0);
                        cfg_wr(ladr, lv);
                        check_state("R3 lo load", hv, lv, 1, 1);
                        cfg_wr(hadr2, ~hv);
                        cfg_wr(ladr2, ~lv);
                        cfg_wr(hadr, 32'h0);
                        check_state("R4 relock cfg", hv, lv, 1, 1);
                        rom_present = 1;
                        rom_wr(1'b1, 32'h5);
                        rom_wr(1'b0, 32'h6);
                        check_state("R4 relock rom", hv, lv, 1, 1);
                    end else begin
                        cfg_wr(hadr, ~hv);
                        cfg_wr(ladr, ~lv);
                        check_state("R5 cfg ignored", 32'h0, 32'h0, 0, 0);
                        rom_wr(la[0], la ? hv : lv);
                        if (la) check_state("R2 rom first hi", hv, 32'h0, 1, 0);
                        else    check_state("R2 rom first lo", 32'h0, lv, 0, 1);
                        rom_wr(!la[0], la ? lv : hv);
                        check_state("R2 rom both", hv, lv, 1, 1);
                        rom_wr(1'b1, 32'h0);
                        rom_present = 0;
                        cfg_wr(hadr2, 32'h1);
                        cfg_wr(ladr2, 32'h2);
                        check_state("R4 relock", hv, lv, 1, 1);
                    end
                    if (k == 7) begin
                        for (int a = 0; a < 256; a++) begin
                            cfg_rd_addr = 8'(a); mmio_rd_addr = 8'(a); #1;
                            chk("R7 cfg sweep", cfg_rd_data, cfg_exp(8'(a), hv, lv));
                            chk("R8 mmio sweep", mmio_rd_data, mm_exp(8'(a), hv, lv));
                        end
                    end
                end
            end
        end

        // all-zero identifier locked: never valid
        rom_present = 0;
        do_reset();
        cfg_wr(8'h70, 32'h0);
        cfg_wr(8'h84, 32'h0);
        check_state("R9 zero id", 32'h0, 32'h0, 1, 1);
        chk("R9 zero id invalid", uid_valid, 1'b0);

        // only low half non-zero but high locked with zero: valid
        do_reset();
        cfg_wr(8'h80, 32'h0);
        check_state("R9 hi only", 32'h0, 32'h0, 1, 0);
        cfg_wr(8'h74, 32'h1);
        check_state("R9 lo nonzero", 32'h0, 32'h1, 1, 1);

        // reset clears loaded state
        do_reset();
        check_state("R1 reset after load", 32'h0, 32'h0, 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule